// File: doc/BRIEF.md
# Multiplexed Host Bus Port

This block is the host-facing front end of a small peripheral on an 8-bit multiplexed address/data bus. One static input selects between two bus conventions that share the same pins. In the first, a level on the read/write pin sets the direction and the data strobe paces the transfer. In the second, the data strobe pin acts as an active-low read strobe and the read/write pin acts as an active-low write strobe. Every pin is sampled by a fast internal clock through a synchronizer, and all edges are found synchronously.

A falling address strobe captures the bus address and a bank-select bit. The bank-select bit picks either the clock register bank or an extra RAM bank of configurable depth. The block drives the captured address to the register storage. During a data phase it also drives per-bank read enables, one-cycle write pulses with the captured write data, and an output enable for the bidirectional data pins. The read data shown on the bus is taken from the bank that is selected.

Top module: `muxbus_host_if`

## Requirements
- R1: A falling edge on `addr_stb` loads `ad_in` into `reg_addr` and `xram_sel` into `reg_bank`, whatever the level of `cs_n`. At any other time both outputs hold their value.
- R2: With `mode_moto`=1, a read phase is active while `data_stb`=1, `rw_stb`=1 and `cs_n`=0. During a read phase `ad_oe`=1 and `ad_out` shows the data of the selected bank.
- R3: With `mode_moto`=1, a falling `data_stb` while `rw_stb`=0 and `cs_n`=0 gives one write pulse lasting exactly one cycle. `reg_wdata` then holds the `ad_in` value that was present at that edge.
- R4: With `mode_moto`=0, a read phase is active while `data_stb`=0 and `cs_n`=0. It then drives `ad_oe` and `ad_out` in the same way as R2.
- R5: With `mode_moto`=0, a rising `rw_stb` while `cs_n`=0 gives one write pulse lasting one cycle. `reg_wdata` then holds the `ad_in` value that was present at that edge.
- R6: While `cs_n`=1, there is no read phase, `ad_oe` stays 0 and no write pulse is produced.
- R7: When `reg_bank`=0, accesses use `clk_rd`/`clk_wr` and `ad_out`=`clk_rdata`. When `reg_bank`=1 and `reg_addr` is below RAM_DEPTH (128), accesses use `ram_rd`/`ram_wr` and `ad_out`=`ram_rdata`. When `reg_bank`=1 and `reg_addr` is 128 or more, there is no enable, no pulse and no `ad_oe`.
- R8: While `rst_n`=0, all enables, pulses and `ad_oe` are 0, and no strobe has any effect. After reset, `reg_addr`=0 and `reg_bank`=0.
- R9: A change on a pin reaches the outputs on the (SYNC_STAGES+1)th rising clock edge after it. With the default of 2 this is the third edge.
- R10: Strobe edges that do not match the selected convention produce no write. In the first convention these are a rising `data_stb`, or a falling `data_stb` with `rw_stb`=1. In the second convention this is a falling `rw_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_moto | input | 1 | 1: direction-level convention, 0: separate-strobe convention (static) |
| addr_stb | input | 1 | Address strobe; its falling edge captures the address |
| data_stb | input | 1 | Data strobe (first convention) or active-low read strobe (second) |
| rw_stb | input | 1 | Direction level (first convention) or active-low write strobe (second) |
| cs_n | input | 1 | Active-low chip select |
| xram_sel | input | 1 | Bank select, captured together with the address |
| ad_in | input | AW | Input side of the multiplexed address/data pins |
| ad_out | output | AW | Read data for the pins, 0 when not enabled |
| ad_oe | output | 1 | Output enable for the address/data pins |
| reg_addr | output | AW | Captured address |
| reg_bank | output | 1 | Captured bank select |
| reg_wdata | output | AW | Write data captured at the write edge |
| clk_rd | output | 1 | Read enable, clock register bank |
| clk_wr | output | 1 | Write pulse, clock register bank |
| ram_rd | output | 1 | Read enable, RAM bank |
| ram_wr | output | 1 | Write pulse, RAM bank |
| clk_rdata | input | AW | Read data from the clock register bank |
| ram_rdata | input | AW | Read data from the RAM bank |

## Verification
The assertions check every cycle that the captured address holds between address strobes, that the two write pulses are mutually exclusive and each last one cycle, and that the outputs stay quiet once chip select has been high for longer than the synchronizer delay. They also check that RAM reads never target an address outside the bank and that nothing is active during reset. Only the bench scenarios can show that each convention decodes the right edge and direction, that address and data arrive intact across every address of both banks, and that the latency matches the stage count.

// File: rtl/hb_pkg.sv
package hb_pkg;

   typedef enum logic {
      BUS_STROBES = 1'b0,
      BUS_DIRLVL  = 1'b1
   } bus_style_e;

   typedef struct packed {
      logic astb;
      logic dstb;
      logic rwl;
      logic csn;
   } ctl_t;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
   parameter int             W      = 8,
   parameter int             STAGES = 2,
   parameter logic [W-1:0]   RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hb_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("hb_sync: W must be positive");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST}};
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hb_addr_latch.sv
module hb_addr_latch #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          as_fall,
   input  logic [AW-1:0] ad_s,
   input  logic          bank_s,
   output logic [AW-1:0] addr_q,
   output logic          bank_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         bank_q <= 1'b0;
      end else if (as_fall) begin
         addr_q <= ad_s;
         bank_q <= bank_s;
      end
   end

   // R1
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !as_fall |=> ($stable(addr_q) && $stable(bank_q)));

endmodule

// File: rtl/hb_strobe_dec.sv
module hb_strobe_dec
   import hb_pkg::*;
(
   input  bus_style_e style,
   input  ctl_t       now_c,
   input  ctl_t       prev_c,
   output logic       rd_phase,
   output logic       wr_fire,
   output logic       as_fall
);

   always_comb begin
      rd_phase = 1'b0;
      wr_fire  = 1'b0;
      as_fall  = prev_c.astb & ~now_c.astb;
      if (!now_c.csn) begin
         if (style == BUS_DIRLVL) begin
            rd_phase = now_c.dstb & now_c.rwl;
            wr_fire  = prev_c.dstb & ~now_c.dstb & ~now_c.rwl;
         end else begin
            rd_phase = ~now_c.dstb;
            wr_fire  = ~prev_c.rwl & now_c.rwl;
         end
      end
   end

endmodule

// File: rtl/muxbus_host_if.sv
module muxbus_host_if
   import hb_pkg::*;
#(
   parameter int AW          = 8,
   parameter int RAM_DEPTH   = 128,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_moto,
   input  logic          addr_stb,
   input  logic          data_stb,
   input  logic          rw_stb,
   input  logic          cs_n,
   input  logic          xram_sel,
   input  logic [AW-1:0] ad_in,
   output logic [AW-1:0] ad_out,
   output logic          ad_oe,
   output logic [AW-1:0] reg_addr,
   output logic          reg_bank,
   output logic [AW-1:0] reg_wdata,
   output logic          clk_rd,
   output logic          clk_wr,
   output logic          ram_rd,
   output logic          ram_wr,
   input  logic [AW-1:0] clk_rdata,
   input  logic [AW-1:0] ram_rdata
);

   localparam int            CW       = 4;
   localparam int            SW       = CW + 1 + AW;
   localparam logic [SW-1:0] SYNC_RST = {4'b0001, 1'b0, {AW{1'b0}}};
   localparam logic [AW:0]   RAM_LIM  = (AW+1)'(RAM_DEPTH);
   localparam int            QUIET    = SYNC_STAGES + 2;
   localparam int            QW       = $clog2(QUIET + 1);

   if (AW < 1 || AW > 16) begin : g_bad_aw
      $error("muxbus_host_if: AW out of range");
   end
   if (RAM_DEPTH < 1 || RAM_DEPTH > (1 << AW)) begin : g_bad_depth
      $error("muxbus_host_if: RAM_DEPTH must fit the address space");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("muxbus_host_if: SYNC_STAGES must be at least 2");
   end

   // pin synchronizer
   logic [SW-1:0] raw_pins, syn_pins, prv_pins;
   assign raw_pins = {addr_stb, data_stb, rw_stb, cs_n, xram_sel, ad_in};

   hb_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST(SYNC_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_pins),
      .q     (syn_pins)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv_pins <= SYNC_RST;
      else        prv_pins <= syn_pins;
   end

   ctl_t          ctl_now, ctl_prev;
   logic          xsel_s;
   logic [AW-1:0] ad_s;
   assign ctl_now  = ctl_t'(syn_pins[SW-1 -: CW]);
   assign ctl_prev = ctl_t'(prv_pins[SW-1 -: CW]);
   assign xsel_s   = syn_pins[AW];
   assign ad_s     = syn_pins[AW-1:0];

   // edge / phase decode
   logic rd_phase, wr_fire, as_fall;

   hb_strobe_dec u_dec (
      .style    (bus_style_e'(mode_moto)),
      .now_c    (ctl_now),
      .prev_c   (ctl_prev),
      .rd_phase (rd_phase),
      .wr_fire  (wr_fire),
      .as_fall  (as_fall)
   );

   // address capture
   logic [AW-1:0] addr_q;
   logic          bank_q;

   hb_addr_latch #(.AW(AW)) u_alat (
      .clk     (clk),
      .rst_n   (rst_n),
      .as_fall (as_fall),
      .ad_s    (ad_s),
      .bank_s  (xsel_s),
      .addr_q  (addr_q),
      .bank_q  (bank_q)
   );

   // RAM bank bound
   logic addr_ok;
   if (RAM_DEPTH == (1 << AW)) begin : g_full_bank
      assign addr_ok = 1'b1;
   end else begin : g_part_bank
      assign addr_ok = {1'b0, addr_q} < RAM_LIM;
   end

   // per-bank enables and pulses
   logic          crd_q, cwr_q, rrd_q, rwr_q;
   logic [AW-1:0] wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crd_q   <= 1'b0;
         cwr_q   <= 1'b0;
         rrd_q   <= 1'b0;
         rwr_q   <= 1'b0;
         wdata_q <= '0;
      end else begin
         crd_q <= rd_phase & ~bank_q;
         cwr_q <= wr_fire  & ~bank_q;
         rrd_q <= rd_phase &  bank_q & addr_ok;
         rwr_q <= wr_fire  &  bank_q & addr_ok;
         if (wr_fire) wdata_q <= ad_s;
      end
   end

   assign clk_rd    = crd_q;
   assign clk_wr    = cwr_q;
   assign ram_rd    = rrd_q;
   assign ram_wr    = rwr_q;
   assign reg_addr  = addr_q;
   assign reg_bank  = bank_q;
   assign reg_wdata = wdata_q;
   assign ad_oe     = crd_q | rrd_q;
   assign ad_out    = rrd_q ? ram_rdata : (crd_q ? clk_rdata : '0);

   // chip-select idle counter for the quiet check
   logic [QW-1:0] cs_hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cs_hi_cnt <= '0;
      else if (!cs_n)                   cs_hi_cnt <= '0;
      else if (cs_hi_cnt != QW'(QUIET)) cs_hi_cnt <= cs_hi_cnt + QW'(1);
   end

   // R3 R5 R7
   wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({clk_wr, ram_wr, clk_rd & ram_rd}));

   // R3 R5
   wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_wr || ram_wr) |=> !(clk_wr || ram_wr));

   // R6
   cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_hi_cnt == QW'(QUIET)) |-> !(ad_oe || clk_wr || ram_wr));

   // R7
   ram_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_rd && $stable(reg_addr)) |-> ({1'b0, reg_addr} < RAM_LIM));

   // R8
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_quiet_chk: assert (!ad_oe && !clk_wr && !ram_wr && !clk_rd && !ram_rd);
      end
   end

endmodule

// File: tb/tb_muxbus_host_if.sv
module tb_muxbus_host_if;

   localparam int AW = 8;
   localparam int RAM_DEPTH = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_moto = 1'b1;
   logic          addr_stb = 1'b0;
   logic          data_stb = 1'b0;
   logic          rw_stb = 1'b1;
   logic          cs_n = 1'b1;
   logic          xram_sel = 1'b0;
   logic [AW-1:0] ad_in = '0;
   logic [AW-1:0] ad_out, reg_addr, reg_wdata, clk_rdata, ram_rdata;
   logic          ad_oe, reg_bank, clk_rd, clk_wr, ram_rd, ram_wr;

   int total = 0;
   int bad = 0;
   int cw_seen = 0, rw_seen = 0, cw_exp = 0, rw_exp = 0;
   logic [AW-1:0] last_addr = '0, last_data = '0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   assign clk_rdata = ~reg_addr;
   assign ram_rdata = reg_addr ^ 8'hA5;

   muxbus_host_if #(.AW(AW), .RAM_DEPTH(RAM_DEPTH), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .mode_moto(mode_moto), .addr_stb(addr_stb),
      .data_stb(data_stb), .rw_stb(rw_stb), .cs_n(cs_n), .xram_sel(xram_sel),
      .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .reg_addr(reg_addr),
      .reg_bank(reg_bank), .reg_wdata(reg_wdata), .clk_rd(clk_rd),
      .clk_wr(clk_wr), .ram_rd(ram_rd), .ram_wr(ram_wr),
      .clk_rdata(clk_rdata), .ram_rdata(ram_rdata)
   );

   always @(negedge clk) begin
      if (clk_wr) begin cw_seen++; last_addr = reg_addr; last_data = reg_wdata; end
      if (ram_wr) begin rw_seen++; last_addr = reg_addr; last_data = reg_wdata; end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic gap(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_mode(input bit m);
      cs_n = 1'b1; addr_stb = 1'b0; rw_stb = 1'b1;
      data_stb = m ? 1'b0 : 1'b1;
      mode_moto = m;
      gap(6);
   endtask

   task automatic latch_addr(input bit bank, input logic [AW-1:0] a);
      xram_sel = bank; ad_in = a; addr_stb = 1'b1;
      gap(4);
      addr_stb = 1'b0;
      gap(5);
      // R1: captured even though chip select is high
      chk(reg_addr == a && reg_bank == bank, "R1 addr", {reg_bank, reg_addr}, {bank, a});
   endtask

   task automatic do_write(input bit sel, input bit bank, input logic [AW-1:0] a,
                           input logic [AW-1:0] d);
      bit hit_c, hit_r;
      hit_c = sel && !bank;
      hit_r = sel && bank && (a < RAM_DEPTH);
      ad_in = d;
      cs_n = ~sel;
      if (mode_moto) begin
         rw_stb = 1'b0; gap(2);
         data_stb = 1'b1; gap(5);
         // R10: rising data strobe gives no write
         chk(cw_seen == cw_exp && rw_seen == rw_exp, "R10 rise", cw_seen + rw_seen, cw_exp + rw_exp);
         data_stb = 1'b0; gap(5);
         cs_n = 1'b1; rw_stb = 1'b1; gap(2);
      end else begin
         rw_stb = 1'b0; gap(5);
         // R10: falling write strobe gives no write
         chk(cw_seen == cw_exp && rw_seen == rw_exp, "R10 fall", cw_seen + rw_seen, cw_exp + rw_exp);
         rw_stb = 1'b1; gap(5);
         cs_n = 1'b1; gap(2);
      end
      if (hit_c) cw_exp++;
      if (hit_r) rw_exp++;
      // R3 R5 R6 R7: pulse count per bank
      chk(cw_seen == cw_exp, mode_moto ? "R3 R7 clk_wr" : "R5 R7 clk_wr", cw_seen, cw_exp);
      chk(rw_seen == rw_exp, sel ? "R7 ram_wr" : "R6 ram_wr", rw_seen, rw_exp);
      if (hit_c || hit_r) begin
         chk(last_addr == a && last_data == d, mode_moto ? "R3 data" : "R5 data",
             {last_addr, last_data}, {a, d});
      end
   endtask

   task automatic do_read(input bit sel, input bit bank, input logic [AW-1:0] a);
      bit exp_oe;
      logic [AW-1:0] exp_d;
      exp_oe = sel && (!bank || a < RAM_DEPTH);
      exp_d  = bank ? (a ^ 8'hA5) : ~a;
      cs_n = ~sel;
      if (mode_moto) begin
         rw_stb = 1'b1; data_stb = 1'b1;
      end else begin
         data_stb = 1'b0;
      end
      gap(5);
      chk(ad_oe == exp_oe, !sel ? "R6 oe" : (mode_moto ? "R2 oe" : "R4 oe"), ad_oe, exp_oe);
      chk(clk_rd == (exp_oe && !bank) && ram_rd == (exp_oe && bank), "R7 rd sel",
          {clk_rd, ram_rd}, {exp_oe && !bank, exp_oe && bank});
      if (exp_oe) chk(ad_out == exp_d, mode_moto ? "R2 data" : "R4 data", ad_out, exp_d);
      data_stb = mode_moto ? 1'b0 : 1'b1;
      gap(5);
      chk(ad_oe == 1'b0, "R2 R4 oe off", ad_oe, 0);
      // R10: falling data strobe with read direction gives no write
      chk(cw_seen == cw_exp && rw_seen == rw_exp, "R10 read", cw_seen + rw_seen, cw_exp + rw_exp);
      cs_n = 1'b1; gap(2);
   endtask

   initial begin
      gap(3);
      // R8: reset state
      chk(!ad_oe && !clk_wr && !ram_wr && !clk_rd && !ram_rd && reg_addr == 0 && !reg_bank,
          "R8 reset", {ad_oe, reg_addr}, 0);
      rst_n = 1'b1;
      gap(4);

      for (int m = 1; m >= 0; m--) begin
         set_mode(m[0]);
         for (int b = 0; b < 2; b++) begin
            for (int a = 0; a < 256; a++) begin
               latch_addr(b[0], a[7:0]);
               do_write(1'b1, b[0], a[7:0], 8'(a * 3 + m + 7 * b));
               do_read(1'b1, b[0], a[7:0]);
            end
         end
         // R6: chip select high, a few addresses
         for (int a = 0; a < 256; a += 51) begin
            latch_addr(1'b0, a[7:0]);
            do_write(1'b0, 1'b0, a[7:0], 8'h3C);
            do_read(1'b0, 1'b0, a[7:0]);
         end
      end

      // R9: latency of SYNC_STAGES+1 edges
      set_mode(1'b1);
      latch_addr(1'b0, 8'h05);
      cs_n = 1'b0; rw_stb = 1'b1; data_stb = 1'b1;
      gap(2);
      chk(ad_oe == 1'b0, "R9 early", ad_oe, 0);
      gap(1);
      chk(ad_oe == 1'b1 && ad_out == 8'hFA, "R9 on time", {ad_oe, ad_out}, {1'b1, 8'hFA});

      // R8: reset during an access
      rst_n = 1'b0;
      gap(1);
      chk(ad_oe == 1'b0, "R8 async", ad_oe, 0);
      rw_stb = 1'b0; data_stb = 1'b0; gap(3);
      data_stb = 1'b1; gap(3); data_stb = 1'b0; gap(5);
      chk(cw_seen == cw_exp && rw_seen == rw_exp && !ad_oe, "R8 blocked",
          cw_seen + rw_seen, cw_exp + rw_exp);
      cs_n = 1'b1; rw_stb = 1'b1;
      gap(2);
      rst_n = 1'b1;
      gap(6);
      chk(reg_addr == 0 && !reg_bank && !ad_oe, "R8 after", {reg_bank, reg_addr}, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule